// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write an external asynchronous static RAM of 512K bytes whose data pins are shared between both directions. The user side presents a request with a 19-bit word address, a write/read select and 8-bit write data. The controller accepts it when `ready` is high and then runs the memory access as a short sequence of phases. Each phase lasts a whole number of clock cycles, derived from nanosecond limits and the clock period given as parameters. Read data comes back on `rd_data`, marked by a single-cycle `rd_valid` pulse.

On the memory side every control and address pin comes straight from a flop. The memory's data pins are modelled as three signals: `mem_dout`, `mem_dout_en` and the sampled `mem_din`. A write is a window in which chip select and write enable are both low. Output enable stays high for the whole window, and the address and data do not change during it or during the cycle after it. A read holds chip select and output enable low, captures the data on the last cycle of the access, and then waits out a turnaround before the next access. Turnaround is arranged so that the controller never drives the data pins while the memory could still be driving them.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dout_en` is 0, `rd_valid` is 0 and `ready` is 1.
- R2: `ready` is 1 only when no access or turnaround is in progress. A request is taken only on a clock edge where `req` and `ready` are both 1. A request raised while `ready` is 0 has no effect on any output.
- R3: A write accepted at edge K holds `mem_cs_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dout_en`=1, with `mem_addr` and `mem_dout` equal to the request, for exactly WP_CYC cycles starting at edge K.
- R4: Right after the write window comes one cycle with `mem_cs_n`=1, `mem_we_n`=1 and `mem_dout_en` still 1, with address and data unchanged. `mem_dout_en` then returns to 0 and `ready` to 1.
- R5: `mem_dout_en` is 1 only while `mem_oe_n` is 1, and it only rises after a cycle in which `mem_oe_n` was already 1.
- R6: A read accepted at edge K holds `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dout_en`=0, with `mem_addr` equal to the request address, for exactly RD_CYC cycles starting at edge K.
- R7: On the edge that ends the read access, `mem_din` is captured into `rd_data`. `rd_valid` is 1 for exactly the one following cycle.
- R8: After a read, `mem_cs_n` and `mem_oe_n` are 1 for TA_CYC cycles before `ready` returns to 1.
- R9: Each phase count is the matching nanosecond limit divided by `CLK_NS` and rounded up, with a minimum of 1. The write window uses the largest of the pulse-width, address-valid and data-setup limits. RD_CYC uses the address access time and TA_CYC the output-release time.
- R10: `mem_oe_n` never falls on an edge where `mem_dout_en` was 1 in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Data for a write request |
| ready | output | 1 | Controller idle, request may be taken |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Value to drive on the data pins |
| mem_dout_en | output | 1 | Drive enable for the data pins |
| mem_din | input | DATA_W | Value sampled from the data pins |

## Verification
The bench uses a clock period of 4 ns, which stretches the write window, the read access and the turnaround to several cycles each. This makes an off-by-one in any phase counter visible. Accesses are issued in four kinds of order: write followed at once by read, read followed at once by write, read after read, and write over write at the same address. The first two orders check the drive handover in both directions, and the same-address cases show whether the last write actually reached the memory. Extreme addresses and all-zero, all-one and alternating data patterns are used to detect stuck or swapped bits. In some stretches the bench holds `req` high with junk payloads while the controller is busy, to show that such requests change nothing at the pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WPULSE = 3'd1,
    PH_WHOLD  = 3'd2,
    PH_RACC   = 3'd3,
    PH_RTURN  = 3'd4
  } phase_t;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int ns_cycles(input int lim_ns, input int clk_ns);
    int c;
    c = (lim_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (!done) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WP_CYC = 1,
  parameter int RD_CYC = 1,
  parameter int TA_CYC = 1,
  parameter int CNT_W  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   req_wr,
  output phase_t nxt_phase,
  output logic   ready,
  output logic   accept_evt,
  output logic   capture_evt
);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

  phase_t           ph_q;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             done;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .done     (done)
  );

  assign ready       = (ph_q == PH_IDLE);
  assign accept_evt  = ready && req;
  assign capture_evt = (ph_q == PH_RACC) && done;

  always_comb begin
    nxt_phase = ph_q;
    ld        = 1'b0;
    ld_val    = '0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req) begin
          ld = 1'b1;
          if (req_wr) begin
            nxt_phase = PH_WPULSE;
            ld_val    = WP_LD;
          end else begin
            nxt_phase = PH_RACC;
            ld_val    = RD_LD;
          end
        end
      end
      PH_WPULSE: if (done) nxt_phase = PH_WHOLD;
      PH_WHOLD:  nxt_phase = PH_IDLE;
      PH_RACC: begin
        if (done) begin
          nxt_phase = PH_RTURN;
          ld        = 1'b1;
          ld_val    = TA_LD;
        end
      end
      PH_RTURN:  if (done) nxt_phase = PH_IDLE;
      default:   nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= nxt_phase;
  end
endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            nxt_phase,
  input  logic              accept_evt,
  input  logic              capture_evt,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic sel_d, we_d, oe_d, drv_d;

  always_comb begin
    sel_d = (nxt_phase == PH_WPULSE) || (nxt_phase == PH_RACC);
    we_d  = (nxt_phase == PH_WPULSE);
    oe_d  = (nxt_phase == PH_RACC);
    drv_d = (nxt_phase == PH_WPULSE) || (nxt_phase == PH_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_dout_en <= 1'b0;
      mem_addr    <= '0;
      mem_dout    <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      mem_cs_n    <= !sel_d;
      mem_we_n    <= !we_d;
      mem_oe_n    <= !oe_d;
      mem_dout_en <= drv_d;
      rd_valid    <= capture_evt;
      if (accept_evt)           mem_addr <= req_addr;
      if (accept_evt && req_wr) mem_dout <= req_wdata;
      if (capture_evt)          rd_data  <= mem_din;
    end
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 10,
  parameter int T_WP_NS = 7,
  parameter int T_AW_NS = 7,
  parameter int T_DW_NS = 5,
  parameter int T_HZ_NS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);
  localparam int WP_CYC  = ns_cycles(max3(T_WP_NS, T_AW_NS, T_DW_NS), CLK_NS);
  localparam int RD_CYC  = ns_cycles(T_AA_NS, CLK_NS);
  localparam int TA_CYC  = ns_cycles(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = max3(WP_CYC, RD_CYC, TA_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_t nxt_phase;
  logic   accept_evt;
  logic   capture_evt;

  sram_ctrl_seq #(
    .WP_CYC (WP_CYC),
    .RD_CYC (RD_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .req_wr      (req_wr),
    .nxt_phase   (nxt_phase),
    .ready       (ready),
    .accept_evt  (accept_evt),
    .capture_evt (capture_evt)
  );

  sram_pin_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .nxt_phase   (nxt_phase),
    .accept_evt  (accept_evt),
    .capture_evt (capture_evt),
    .req_wr      (req_wr),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .mem_din     (mem_din),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              accept_evt,
  input logic              capture_evt,
  input logic              rd_valid,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dout_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dout
);
  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dout_en));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !ready);

  assert_write_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dout_en));

  assert_write_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dout_en && mem_cs_n && $stable(mem_addr) && $stable(mem_dout)));

  assert_drive_oe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> mem_oe_n);

  assert_drive_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dout_en) |-> $past(mem_oe_n));

  assert_read_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));

  assert_capture_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (rd_valid && mem_oe_n && mem_cs_n));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !ready);

  assert_release_before_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dout_en));
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready       (ready),
  .accept_evt  (accept_evt),
  .capture_evt (capture_evt),
  .rd_valid    (rd_valid),
  .mem_cs_n    (mem_cs_n),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_dout_en (mem_dout_en),
  .mem_addr    (mem_addr),
  .mem_dout    (mem_dout)
);

// File: tb/sim_sram_bus_ctrl.sv
`timescale 1ns/1ps
module sim_sram_bus_ctrl;
  localparam int CLK_PERIOD = 4;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int WATCHDOG = 5000;

  // Phase lengths restated from R9: count up until the cycles cover the limit.
  function automatic int cover_ns(input int lim);
    int c = 1;
    while (c * CLK_PERIOD < lim) c++;
    return c;
  endfunction
  localparam int WP_N = cover_ns(7);   // largest of 7, 7, 5
  localparam int RD_N = cover_ns(10);
  localparam int TA_N = cover_ns(5);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en;
  logic [DW-1:0] rd_data, mem_dout;
  logic [DW-1:0] mem_din = '0;
  logic [AW-1:0] mem_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bus_ctrl #(.CLK_NS(CLK_PERIOD)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  typedef struct {
    bit cs_n, we_n, oe_n, drv, rv, rdy, chk_a, chk_d;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [DW-1:0] rd;
    string tag;
  } exp_t;

  exp_t q[$];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] store [int];
  int nvec = 0, nbad = 0;

  int op_wr[16], op_a[16], op_d[16], op_gap[16], op_noise[16];
  int n_ops = 0;

  task automatic add_op(input int wr, input int a, input int d, input int gap, input int noise);
    op_wr[n_ops] = wr; op_a[n_ops] = a; op_d[n_ops] = d;
    op_gap[n_ops] = gap; op_noise[n_ops] = noise;
    n_ops++;
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    nvec++;
    if (act !== expv) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(input bit cs, input bit we, input bit oe, input bit drv, input string tag);
    exp_t e;
    e.cs_n = cs; e.we_n = we; e.oe_n = oe; e.drv = drv; e.tag = tag;
    e.rv = 0; e.rdy = 0; e.chk_a = 0; e.chk_d = 0; e.a = '0; e.d = '0; e.rd = '0;
    return e;
  endfunction

  initial begin
    exp_t e;
    bit was_idle, pend, finished;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;
    int op_i, gap, noise, cyc;
    op_i = 0; gap = 0; noise = 0; cyc = 0; pend = 0; finished = 0; wa = '0; wd = '0;

    add_op(1, 'h00000, 'hA5, 0, 0);
    add_op(1, 'h7FFFF, 'h3C, 0, 0);
    add_op(0, 'h00000, 0, 0, 0);     // read right after a write
    add_op(0, 'h7FFFF, 0, 2, 0);
    add_op(1, 'h12345, 'hFF, 0, 0);  // write right after a read
    add_op(1, 'h12345, 'h00, 0, 0);  // overwrite
    add_op(0, 'h12345, 0, 0, 0);
    add_op(0, 'h12345, 0, 0, 0);     // read after read
    add_op(1, 'h00001, 'h5A, 0, 1);
    add_op(0, 'h00001, 0, 0, 1);
    add_op(1, 'h2AAAA, 'h81, 0, 1);
    add_op(0, 'h2AAAA, 0, 1, 1);
    add_op(0, 'h00000, 0, 0, 0);

    // R1: reset state
    repeat (3) @(negedge clk);
    cmp("R1", "cs_n", mem_cs_n, 1);
    cmp("R1", "we_n", mem_we_n, 1);
    cmp("R1", "oe_n", mem_oe_n, 1);
    cmp("R1", "dout_en", mem_dout_en, 0);
    cmp("R1", "ready", ready, 1);
    cmp("R1", "rd_valid", rd_valid, 0);
    rst_n = 1'b1;

    while (cyc < WATCHDOG && !finished) begin
      @(negedge clk);
      cyc++;

      // Pin-level memory: a write lands when the low-low window closes.
      if (!mem_cs_n && !mem_we_n) begin
        pend = 1; wa = mem_addr; wd = mem_dout;
      end else if (pend) begin
        store[int'(wa)] = wd; pend = 0;
      end
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
        mem_din = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
        cmp("R10", "contention", mem_dout_en, 0);
      end else begin
        mem_din = 8'hxx;
      end

      // Compare against the reference sequence
      was_idle = (q.size() == 0);
      if (was_idle) begin
        e = mk(1, 1, 1, 0, "R2"); e.rdy = 1;
      end else begin
        e = q.pop_front();
      end
      cmp(e.tag, "cs_n", mem_cs_n, e.cs_n);
      cmp(e.tag, "we_n", mem_we_n, e.we_n);
      cmp(e.tag, "oe_n", mem_oe_n, e.oe_n);
      cmp({e.tag, ",R5"}, "dout_en", mem_dout_en, e.drv);
      cmp({e.tag, ",R2"}, "ready", ready, e.rdy);
      cmp({e.tag, ",R7"}, "rd_valid", rd_valid, e.rv);
      if (e.chk_a) cmp(e.tag, "addr", mem_addr, e.a);
      if (e.chk_d) cmp(e.tag, "dout", mem_dout, e.d);
      if (e.rv) cmp("R7", "rd_data", rd_data, e.rd);

      // Stimulus
      if (was_idle) begin
        if (gap > 0) begin
          gap--; req = 0;
        end else if (op_i < n_ops) begin
          req = 1; req_wr = op_wr[op_i][0];
          req_addr = AW'(op_a[op_i]); req_wdata = DW'(op_d[op_i]);
          if (op_wr[op_i] != 0) begin
            shadow[op_a[op_i]] = DW'(op_d[op_i]);
            for (int i = 0; i < WP_N; i++) begin   // R3,R9 write window
              e = mk(0, 0, 1, 1, "R3,R9"); e.chk_a = 1; e.chk_d = 1;
              e.a = AW'(op_a[op_i]); e.d = DW'(op_d[op_i]); q.push_back(e);
            end
            e = mk(1, 1, 1, 1, "R4"); e.chk_a = 1; e.chk_d = 1;
            e.a = AW'(op_a[op_i]); e.d = DW'(op_d[op_i]); q.push_back(e);
          end else begin
            for (int i = 0; i < RD_N; i++) begin   // R6,R9 read access
              e = mk(0, 1, 0, 0, "R6,R9"); e.chk_a = 1; e.a = AW'(op_a[op_i]);
              q.push_back(e);
            end
            for (int i = 0; i < TA_N; i++) begin   // R8 turnaround
              e = mk(1, 1, 1, 0, "R8");
              if (i == 0) begin e.rv = 1; e.rd = shadow[op_a[op_i]]; end
              q.push_back(e);
            end
          end
          gap = op_gap[op_i]; noise = op_noise[op_i];
          op_i++;
        end else begin
          req = 0; finished = 1;
        end
      end else if (noise != 0) begin
        // R2: junk requests while busy must not be taken
        req = 1; req_wr = cyc[0];
        req_addr = AW'(cyc * 7919); req_wdata = DW'(cyc * 37);
      end else begin
        req = 0;
      end
    end

    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL R2 watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule